// File: doc/BRIEF.md
# Memory-Card Slot Control Registers

This block is a small control and status register set for one memory-card slot. It sits on a word-addressed register bus with a one-cycle write strobe and combinational read data. Two words are fixed: an identification word and a decode-status word. A third word reads zero, and software writes to it have no effect.

The interrupt word carries two kinds of bit. Bit 0 shows the level of the card write-protect input. Bit 3 captures a card-insertion event. Bit 3 sets whenever the card-insert input is high and stays set after that input drops. Software clears it by writing the word with a one in bit 3. The interrupt output is bit 3 alone, so an insertion stays pending until software acknowledges it.

Top module: `card_slot_ctrl`

## Requirements
- R1: A read at word address 0 returns 0x41034003.
- R2: A read at word address 1 returns 0. A write there does not change what address 1, 2 or 3 reads back.
- R3: A read at word address 3 returns 0x00000011. A write there does not change what address 1, 2 or 3 reads back.
- R4: Bit 0 of the word at address 2 equals the level that `wp_i` had at the previous rising clock edge.
- R5: Bit 3 of the word at address 2 becomes 1 after any rising clock edge where `cd_i` is high. It stays 1 after `cd_i` falls until it is cleared.
- R6: A write to address 2 with a 1 in data bit 3 clears bit 3 at that edge. A write with a 0 in bit 3 leaves it set, and no write changes bit 0.
- R7: `irq_o` always equals bit 3 of the word at address 2.
- R8: If `cd_i` is high at the same edge as a clearing write, bit 3 remains 1.
- R9: All bits of the word at address 2 other than bits 0 and 3 read 0. After reset, that word reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address for both reads and writes |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| wp_i | input | 1 | Card write-protect level |
| cd_i | input | 1 | Card-insert indication |
| irq_o | output | 1 | Card-insertion interrupt, high while the event is pending |

## Verification
On every cycle, the embedded properties check four things: the write-protect bit tracks its input with one edge of delay; an insert input sets the sticky bit even when a clear is requested; the sticky bit holds unless it is cleared; and it can fall only after an accepted clear. The bench scenarios cover the rest. They read the fixed words, check that writes to the constant addresses leave every readable word unchanged, and check the reset value. They also show that a clear written with bit 3 at zero leaves the pending interrupt in place. Only a scenario can show the insert-pulse-then-release sequence, with the bit still set long after `cd_i` drops.

// File: rtl/card_slot_pkg.sv
package card_slot_pkg;
  localparam logic [31:0] SLOT_ID_VAL     = 32'h4103_4003;
  localparam logic [31:0] SLOT_DECODE_VAL = 32'h0000_0011;
  localparam int unsigned OFS_ID     = 0;
  localparam int unsigned OFS_FLASH  = 1;
  localparam int unsigned OFS_EVT    = 2;
  localparam int unsigned OFS_DECODE = 3;
endpackage

// File: rtl/card_slot_evt.sv
module card_slot_evt #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WP_BIT = 0,
  parameter int unsigned CD_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wp_i,
  input  logic              cd_i,
  output logic [DATA_W-1:0] evt_word_o,
  output logic              pend_o
);
  logic wp_q, cd_q, clr;

  assign clr = clr_wr_i & wdata_i[CD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= 1'b0;
      cd_q <= 1'b0;
    end else begin
      wp_q <= wp_i;
      // set wins over clear
      cd_q <= cd_i | (cd_q & ~clr);
    end
  end

  always_comb begin
    evt_word_o         = '0;
    evt_word_o[WP_BIT] = wp_q;
    evt_word_o[CD_BIT] = cd_q;
  end

  assign pend_o = cd_q;

  // R4
  wp_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> wp_q == $past(wp_i));
  // R5 R8
  cd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_i |=> cd_q);
  // R5
  cd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_q && !clr_wr_i) |=> cd_q);
  // R6
  cd_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cd_q) |-> $past(clr_wr_i && wdata_i[CD_BIT]));
endmodule

// File: rtl/card_slot_rdmux.sv
module card_slot_rdmux
  import card_slot_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] evt_word_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (int'(addr_i))
      OFS_ID:     rdata_o = DATA_W'(SLOT_ID_VAL);
      OFS_FLASH:  rdata_o = '0;
      OFS_EVT:    rdata_o = evt_word_i;
      OFS_DECODE: rdata_o = DATA_W'(SLOT_DECODE_VAL);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/card_slot_ctrl.sv
module card_slot_ctrl
  import card_slot_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned WP_BIT = 0,
  parameter int unsigned CD_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wp_i,
  input  logic              cd_i,
  output logic              irq_o
);
  logic              evt_wr;
  logic [DATA_W-1:0] evt_word;

  // only the event word has writable state; other offsets drop writes
  assign evt_wr = wr_en_i && (int'(addr_i) == OFS_EVT);

  card_slot_evt #(.DATA_W(DATA_W), .WP_BIT(WP_BIT), .CD_BIT(CD_BIT)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_wr_i  (evt_wr),
    .wdata_i   (wdata_i),
    .wp_i      (wp_i),
    .cd_i      (cd_i),
    .evt_word_o(evt_word),
    .pend_o    (irq_o)
  );

  card_slot_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
    .addr_i    (addr_i),
    .evt_word_i(evt_word),
    .rdata_o   (rdata_o)
  );

  // R7
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) == OFS_EVT) |-> irq_o == rdata_o[CD_BIT]);
endmodule

// File: tb/card_slot_ctrl_test.sv
module card_slot_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wp_i = 1'b0;
  logic        cd_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  card_slot_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(2'd2, d);
    chk("R9 reset word", d, 32'h0);
    chk("R9 reset irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_const();
    logic [31:0] d;
    bus_rd(2'd0, d); chk("R1 id", d, 32'h4103_4003);
    bus_rd(2'd1, d); chk("R2 zero word", d, 32'h0);
    bus_rd(2'd3, d); chk("R3 decode", d, 32'h11);
  endtask

  task automatic t_wp();
    logic [31:0] d;
    @(negedge clk_i); wp_i = 1'b1;
    @(negedge clk_i);
    bus_rd(2'd2, d); chk("R4 wp high", d, 32'h1);
    chk("R9 other bits", d & ~32'h9, 32'h0);
    wp_i = 1'b0;
    @(negedge clk_i);
    bus_rd(2'd2, d); chk("R4 wp low", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    @(negedge clk_i); cd_i = 1'b1;
    @(negedge clk_i); cd_i = 1'b0;
    bus_rd(2'd2, d); chk("R5 set", d, 32'h8);
    chk("R7 irq set", {31'b0, irq_o}, 32'h1);
    repeat (5) @(negedge clk_i);
    bus_rd(2'd2, d); chk("R5 held", d, 32'h8);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wp_i = 1'b1;
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_wr(2'd3, 32'hFFFF_FFFF);
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd1, d); chk("R2 write dropped", d, 32'h0);
    bus_rd(2'd3, d); chk("R3 write dropped", d, 32'h11);
    bus_rd(2'd2, d); chk("R2 R3 evt untouched", d, 32'h9);
    chk("R7 irq kept", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_wr(2'd2, 32'hFFFF_FFF7);
    bus_rd(2'd2, d); chk("R6 no bit3 no clear", d, 32'h9);
    bus_wr(2'd2, 32'h0000_0008);
    bus_rd(2'd2, d); chk("R6 cleared, wp kept", d, 32'h1);
    chk("R7 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    @(negedge clk_i);
    addr_i = 2'd2; wdata_i = 32'h8; wr_en_i = 1'b1; cd_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; cd_i = 1'b0; wdata_i = '0;
    bus_rd(2'd2, d); chk("R8 set beats clear", d & 32'h8, 32'h8);
    chk("R7 irq on", {31'b0, irq_o}, 32'h1);
    bus_wr(2'd2, 32'h8);
    bus_rd(2'd2, d); chk("R6 clear after", d & 32'h8, 32'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_const();
    t_wp();
    t_sticky();
    t_ignored();
    t_clear();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule